// File: doc/BRIEF.md
# Shared-Address Interrupt Enable and Status Registers

This block holds a small set of byte-wide interrupt registers behind a simple register bus. Each register uses one address for two jobs. A write to it loads the per-bit interrupt enables. A read from it returns the latched interrupt status and clears that status in the same access. The enables are write-only, and no address returns them. The event sources are level signals from supervisor circuits. These are a supply brown-out detector, a junction over-temperature detector and an oscillator-stopped watchdog. The block combines all enabled, latched events into one interrupt request line.

The default configuration has two registers at adjacent offsets, 25h and 26h. At 25h, bit 0 is brown-out and bit 1 is the oscillator-stopped watchdog. At 26h, bit 7 is over-temperature. The watchdog bit is sticky-regardless-of-enable. It latches while its enable is 0, so a loss of the backup supply during power-down can still be seen later. To get a meaningful watchdog reading, software writes its enable to 1 before reading the status. Parameters choose the base offset, the number of registers, the bits that are implemented and the bits that latch regardless of enable. The only reset is the analog-supply power-on reset.

Top module: `irq_shared_regs`

## Requirements
- R1: After power-on reset, all status and enable bits are 0, `bus_rdata_o` is 00h and `irq_o` is 0.
- R2: A write to 25h or 26h loads that register's enables, where bit value 1 enables and 0 disables. An enabled source whose level input is high at a clock edge sets its status bit at that edge.
- R3: A read of 25h or 26h presents the register's status on `bus_rdata_o` one clock after the read cycle. The status is cleared in that same access, so a second read returns 00h once the source is low.
- R4: Enables cannot be read back. A read after writing FFh returns only status bits.
- R5: A brown-out or over-temperature level that arrives while its enable is 0 leaves the status bit at 0.
- R6: Watchdog bit 1 at 25h latches from its level input even when its enable is 0.
- R7: `irq_o` is 1 exactly when some bit has both its status and its enable at 1. For this reason a latched but disabled watchdog bit does not raise `irq_o` until its enable is written to 1.
- R8: A latching event in the same cycle as a clearing read leaves the bit set after the read. The read returns the old status.
- R9: A level that stays high through a clearing read keeps the status bit set on the following clock.
- R10: Unimplemented bits always read 0. These are bits 7..2 at 25h and bits 6..0 at 26h, including unused bit 6 at 26h.
- R11: A read of any other address returns 00h and clears no status.
- R12: Over-temperature is bit 7 at 26h, driven by `src_lvl_i[15]`. Brown-out is `src_lvl_i[0]` and watchdog is `src_lvl_i[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| por_n_i | input | 1 | Active-low analog-supply power-on reset |
| bus_addr_i | input | 8 | Register offset |
| bus_wr_i | input | 1 | Write strobe, loads enables of addressed register |
| bus_rd_i | input | 1 | Read strobe, returns and clears addressed status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| src_lvl_i | input | 16 | Level event inputs, 8 per register, register at 25h in bits 7..0 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the source levels and the bus strobes are synchronous to `clk_i` and stable around each rising edge. They also assume that a read strobe lasts exactly one cycle per access. The bench drives every input on the falling edge and holds each strobe for a single cycle. It samples results on the next falling edge, so each event and each read lands on a known rising edge. Source pulses are one cycle wide unless a test needs a level held through a read.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
   localparam int unsigned BUS_AW = 8;
   localparam int unsigned BUS_DW = 8;
   typedef logic [BUS_AW-1:0] bus_addr_t;
   typedef logic [BUS_DW-1:0] bus_data_t;
endpackage

// File: rtl/irq_bit_cell.sv
`timescale 1ns/1ps
module irq_bit_cell #(
   parameter bit STICKY = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic en_i,
   input  logic clr_i,
   output logic status_o
);
   logic status_q;
   logic arm;

   generate
      if (STICKY) begin : g_sticky
         logic unused_en;
         assign unused_en = en_i;
         assign arm = 1'b1;
         // R6
         sticky_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lvl_i |=> status_q);
      end else begin : g_gated
         assign arm = en_i;
         // R5
         gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!en_i && !status_q) |=> !status_q);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q <= 1'b0;
      else         status_q <= (status_q & ~clr_i) | (lvl_i & arm);
   end

   assign status_o = status_q;

   // R8
   evt_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && lvl_i && (en_i || STICKY)) |=> status_q);
endmodule

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank #(
   parameter int unsigned DW     = 8,
   parameter logic [DW-1:0] IMPL   = '0,
   parameter logic [DW-1:0] STICKY = '0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic          rd_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] lvl_i,
   output logic [DW-1:0] status_o,
   output logic          irq_o
);
   logic [DW-1:0] en_q;
   logic [DW-1:0] stat;
   logic          unused_bits;

   if ((STICKY & ~IMPL) != '0) begin : g_cfg_bad
      $error("sticky bits must be implemented bits");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q <= '0;
      else if (wr_i) en_q <= wdata_i & IMPL;
   end

   assign unused_bits = ^(lvl_i & ~IMPL) ^ ^(wdata_i & ~IMPL);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (IMPL[b]) begin : g_live
         irq_bit_cell #(.STICKY(STICKY[b])) u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .lvl_i    (lvl_i[b]),
            .en_i     (en_q[b]),
            .clr_i    (rd_i),
            .status_o (stat[b])
         );
      end else begin : g_void
         assign stat[b] = 1'b0;
      end
   end

   assign status_o = stat;
   assign irq_o    = |(stat & en_q);

   // R3 R7
   clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && ((lvl_i & IMPL) == '0)) |=> !irq_o);
endmodule

// File: rtl/irq_shared_regs.sv
`timescale 1ns/1ps
module irq_shared_regs
   import irq_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 2,
   parameter int unsigned BASE_ADDR = 'h25,
   parameter logic [NUM_REGS*BUS_DW-1:0] IMPL_MASK   = 16'h8003,
   parameter logic [NUM_REGS*BUS_DW-1:0] STICKY_MASK = 16'h0002
) (
   input  logic                       clk_i,
   input  logic                       por_n_i,
   input  logic [BUS_AW-1:0]          bus_addr_i,
   input  logic                       bus_wr_i,
   input  logic                       bus_rd_i,
   input  logic [BUS_DW-1:0]          bus_wdata_i,
   output logic [BUS_DW-1:0]          bus_rdata_o,
   input  logic [NUM_REGS*BUS_DW-1:0] src_lvl_i,
   output logic                       irq_o
);
   localparam int unsigned LAST_ADDR = BASE_ADDR + NUM_REGS - 1;

   if (NUM_REGS < 1) begin : g_cnt_bad
      $error("NUM_REGS must be at least 1");
   end
   if (LAST_ADDR >= (1 << BUS_AW)) begin : g_addr_bad
      $error("register window exceeds address space");
   end

   logic [NUM_REGS-1:0] sel;
   logic [NUM_REGS-1:0] bank_irq;
   bus_data_t           bank_stat [NUM_REGS];
   bus_data_t           rd_mux;
   bus_data_t           rdata_q;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
      localparam bus_addr_t ADDR_R = BUS_AW'(BASE_ADDR + r);
      assign sel[r] = (bus_addr_i == ADDR_R);
      irq_bank #(
         .DW     (BUS_DW),
         .IMPL   (IMPL_MASK[r*BUS_DW +: BUS_DW]),
         .STICKY (STICKY_MASK[r*BUS_DW +: BUS_DW])
      ) u_bank (
         .clk_i    (clk_i),
         .rst_ni   (por_n_i),
         .wr_i     (bus_wr_i & sel[r]),
         .rd_i     (bus_rd_i & sel[r]),
         .wdata_i  (bus_wdata_i),
         .lvl_i    (src_lvl_i[r*BUS_DW +: BUS_DW]),
         .status_o (bank_stat[r]),
         .irq_o    (bank_irq[r])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (sel[r]) rd_mux = rd_mux | bank_stat[r];
      end
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)      rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_mux;
   end

   assign bus_rdata_o = rdata_q;
   assign irq_o       = |bank_irq;

   // R11
   miss_read_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (bus_rd_i && (sel == '0)) |=> (bus_rdata_o == '0));

   // R7
   irq_cause_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(irq_o) |-> $past((|src_lvl_i) || bus_wr_i));
endmodule

// File: tb/irq_shared_regs_test.sv
`timescale 1ns/1ps
module irq_shared_regs_test;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [15:0] src = '0;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   logic [7:0]  d;

   always #10 clk = ~clk;

   irq_shared_regs uut (
      .clk_i(clk), .por_n_i(por_n), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .src_lvl_i(src), .irq_o(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] v);
      @(negedge clk); addr = a; wdata = v; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; v = rdata;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); src[idx] = 1'b1;
      @(negedge clk); src[idx] = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 rdata", rdata, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      bus_read(8'h25, d); check("R1 status 25h", d, 8'h00);
      bus_read(8'h26, d); check("R1 status 26h", d, 8'h00);
   endtask

   task automatic t_enable_latch;
      bus_write(8'h25, 8'h01);
      pulse(0);
      check("R7 irq set", {7'd0, irq}, 8'h01);
      bus_read(8'h25, d); check("R2 R3 read status", d, 8'h01);
      check("R7 irq cleared", {7'd0, irq}, 8'h00);
      bus_read(8'h25, d); check("R3 cleared", d, 8'h00);
   endtask

   task automatic t_no_readback;
      bus_write(8'h26, 8'hFF);
      bus_read(8'h26, d); check("R4 no enable readback", d, 8'h00);
      bus_write(8'h26, 8'h80);
   endtask

   task automatic t_disabled;
      bus_write(8'h25, 8'h00);
      pulse(0);
      check("R5 irq", {7'd0, irq}, 8'h00);
      bus_read(8'h25, d); check("R5 status", d, 8'h00);
   endtask

   task automatic t_sticky;
      pulse(1);
      check("R6 R7 irq off while disabled", {7'd0, irq}, 8'h00);
      bus_write(8'h25, 8'h02);
      check("R7 irq after enable", {7'd0, irq}, 8'h01);
      bus_read(8'h25, d); check("R6 status", d, 8'h02);
      check("R7 irq after read", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_overtemp;
      pulse(15);
      check("R12 irq", {7'd0, irq}, 8'h01);
      bus_read(8'h26, d); check("R12 status", d, 8'h80);
   endtask

   task automatic t_same_cycle;
      bus_write(8'h25, 8'h01);
      pulse(0);
      @(negedge clk); src[0] = 1'b1; addr = 8'h25; rd = 1'b1;
      @(negedge clk); src[0] = 1'b0; rd = 1'b0;
      check("R8 old status", rdata, 8'h01);
      bus_read(8'h25, d); check("R8 kept", d, 8'h01);
      bus_read(8'h25, d); check("R8 then clear", d, 8'h00);
   endtask

   task automatic t_level_held;
      @(negedge clk); src[0] = 1'b1;
      bus_read(8'h25, d); check("R9 first", d, 8'h01);
      check("R9 irq held", {7'd0, irq}, 8'h01);
      bus_read(8'h25, d); check("R9 again", d, 8'h01);
      src[0] = 1'b0;
      bus_read(8'h25, d); check("R9 last", d, 8'h01);
      bus_read(8'h25, d); check("R9 clear", d, 8'h00);
   endtask

   task automatic t_unused;
      bus_write(8'h25, 8'hFF);
      bus_write(8'h26, 8'hFF);
      @(negedge clk); src = 16'h7FFC;
      @(negedge clk); @(negedge clk); src = '0;
      check("R10 irq", {7'd0, irq}, 8'h00);
      bus_read(8'h25, d); check("R10 25h", d, 8'h00);
      bus_read(8'h26, d); check("R10 26h bit6", d, 8'h00);
   endtask

   task automatic t_unmapped;
      bus_write(8'h25, 8'h01);
      pulse(0);
      bus_read(8'h27, d); check("R11 27h", d, 8'h00);
      bus_read(8'h24, d); check("R11 24h", d, 8'h00);
      check("R11 irq kept", {7'd0, irq}, 8'h01);
      bus_read(8'h25, d); check("R11 not cleared", d, 8'h01);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      t_reset();
      t_enable_latch();
      t_no_readback();
      t_disabled();
      t_sticky();
      t_overtemp();
      t_same_cycle();
      t_level_held();
      t_unused();
      t_unmapped();
      finish_run();
   end

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule